// File: doc/BRIEF.md
# Interrupt and Power-Down Event Router

This block collects the interrupt lines of two serial ports and the levels of two general-purpose pins for a peripheral that presents two functions to its host. Each pin first passes through an optional inversion, selected by an external control input. Every source then has its own enable mask. The serial ports always feed function 0. Each pin feeds whichever function its route bit selects. Each function's interrupt output is the registered OR of the enabled sources routed to it.

Pin 0 can also request power-down. When its power-down enable is set and it is routed to function 1, a high pin state sets function 1's sticky request on the next clock edge. When it is routed to function 0, a state machine qualifies the request first. Both serial ports must report power-down and pin 0 must be high on every edge of a `FILTER_CYCLES`-long run before function 0's sticky request is set. The machine has three states. `FLT_IDLE` goes to `FLT_COUNT` when all three conditions hold. `FLT_COUNT` returns to `FLT_IDLE` on any break. It goes to `FLT_FIRED` on the last edge of the run, where it raises a one-cycle fire pulse. `FLT_FIRED` returns to `FLT_IDLE` once the condition drops.

All control and status sits in one 32-bit word. It is written with a single strobe and read back combinationally.

Top module: `irq_pd_router`

## Requirements
- R1: After reset, every mask, routing and power-down enable bit and both sticky bits are 0, both interrupt outputs are 0, and the read word is 0 while all inputs are 0.
- R2: Read bits 1:0 show serial port interrupts 1 and 0 live. Read bits 3:2 show pin 1 and pin 0 XOR their inversion inputs, also live.
- R3: Read bits 15:4, 21, 25:24 and 31:28 are always 0, and writing 1 to them has no effect. Writing all ones sets bits 16 to 20, 26 and 27 and reads back as 0x0C1F0000 when the live bits are 0.
- R4: Bit 16 (port 0) and bit 17 (port 1) enable the serial ports onto function 0. `fn0_irq` follows an enabled port one clock edge after the mask is in place, and a port whose mask is clear has no effect.
- R5: Bits 18 and 19 enable pins 0 and 1 as interrupt sources. Bit 26 (pin 0) and bit 27 (pin 1) route the pin to function 1 when set and to function 0 when clear. The chosen output follows one edge later, and the other output is not driven by that pin.
- R6: With bit 20 set and bit 26 set, a high pin-0 state sets sticky bit 23 (function 1) on the next clock edge, with no filtering.
- R7: With bit 20 set and bit 26 clear, sticky bit 22 (function 0) is set on the edge that completes `FILTER_CYCLES` consecutive edges at which both serial power-down inputs and the pin-0 state were all high. It is not set earlier.
- R8: A single edge at which any of the three function-0 conditions is low restarts the count from zero.
- R9: Writing 1 to bit 22 or 23 clears that sticky bit, and writing 0 leaves it unchanged. A set occurring in the same edge as a clear wins.
- R10: Function 0's filter fires once per unbroken condition run. After the sticky bit is cleared, it stays clear while the condition remains held.
- R11: With bit 20 clear, neither sticky bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_irq | input | 2 | Internal interrupt lines of serial ports 1:0 |
| uart_pd | input | 2 | Power-down indications of serial ports 1:0 |
| gp_pin | input | 2 | Raw levels of general-purpose pins 1:0 |
| gp_invert | input | 2 | Per-pin inversion select |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read of the control/status word |
| fn0_irq | output | 1 | Function 0 interrupt, active high, registered |
| fn1_irq | output | 1 | Function 1 interrupt, active high, registered |
| pd_sticky | output | 2 | Sticky power-down requests, bit 0 is function 0 and bit 1 is function 1 |

## Verification
The hardest case to reach is the filtered function-0 request landing on exactly the right edge. Three independent inputs and two control bits must all stay high for the full run, and a break anywhere must cost the whole count. Directed sequences hold the condition for one edge less than the period and then one more. They insert a single-edge break after an almost-complete run, and they clear the sticky bit while the condition is still held. Random phases bias the power-down inputs and pin 0 towards high and favour writes that keep the pin routed to function 0. This lets full runs, interrupted runs and same-edge set/clear collisions all occur, and a cycle-level bench model checks each of them.

// File: rtl/irq_pd_pkg.sv
package irq_pd_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_UART  = 2;
    localparam int unsigned NUM_PIN   = 2;

    // bit positions inside the control/status word
    localparam int unsigned B_UIRQ    = 0;
    localparam int unsigned B_PIN     = 2;
    localparam int unsigned B_UMASK   = 16;
    localparam int unsigned B_PMASK   = 18;
    localparam int unsigned B_PDMASK  = 20;
    localparam int unsigned B_STICKY  = 22;
    localparam int unsigned B_ROUTE   = 26;

    typedef enum logic [1:0] {
        FLT_IDLE  = 2'd0,
        FLT_COUNT = 2'd1,
        FLT_FIRED = 2'd2
    } flt_state_t;

    typedef struct packed {
        logic [NUM_PIN-1:0]  route;
        logic                pd_mask;
        logic [NUM_PIN-1:0]  pin_mask;
        logic [NUM_UART-1:0] uart_mask;
    } ctl_t;

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
    parameter int unsigned N_PINS = 2
) (
    input  logic [N_PINS-1:0] pin_raw,
    input  logic [N_PINS-1:0] invert,
    output logic [N_PINS-1:0] pin_state
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign pin_state[i] = invert[i] ? ~pin_raw[i] : pin_raw[i];
    end

endmodule

// File: rtl/pd_filter.sv
module pd_filter
    import irq_pd_pkg::*;
#(
    parameter int unsigned PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic fire
);

    localparam int unsigned CNT_W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    flt_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            FLT_IDLE: begin
                if (hold) begin
                    state_n = FLT_COUNT;
                    cnt_n   = CNT_W'(1);
                end
            end
            FLT_COUNT: begin
                if (!hold) begin
                    state_n = FLT_IDLE;
                    cnt_n   = '0;
                end else if (cnt == LAST) begin
                    state_n = FLT_FIRED;
                    cnt_n   = '0;
                end else begin
                    cnt_n   = cnt + CNT_W'(1);
                end
            end
            FLT_FIRED: begin
                if (!hold) state_n = FLT_IDLE;
            end
            default: begin
                state_n = FLT_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (state)
            FLT_COUNT: fire = hold && (cnt == LAST);
            FLT_IDLE,
            FLT_FIRED: fire = 1'b0;
            default:   fire = 1'b0;
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FLT_COUNT) |-> (cnt != '0) && (cnt <= LAST)); // R7
    AST_BREAK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FLT_IDLE) && !hold |=> (state == FLT_IDLE)); // R8
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R10

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int unsigned NUM_UART = 2,
    parameter int unsigned NUM_PIN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_UART-1:0] uart_irq,
    input  logic [NUM_UART-1:0] uart_en,
    input  logic [NUM_PIN-1:0]  pin_state,
    input  logic [NUM_PIN-1:0]  pin_en,
    input  logic [NUM_PIN-1:0]  pin_sel,
    output logic [1:0]          fn_irq
);

    logic [NUM_PIN-1:0] to_f0, to_f1;

    for (genvar i = 0; i < NUM_PIN; i++) begin : g_route
        assign to_f0[i] = pin_state[i] & pin_en[i] & ~pin_sel[i];
        assign to_f1[i] = pin_state[i] & pin_en[i] &  pin_sel[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_irq <= 2'b00;
        end else begin
            fn_irq[0] <= (|(uart_irq & uart_en)) | (|to_f0);
            fn_irq[1] <= |to_f1;
        end
    end

    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_en == '0) && (pin_en == '0) |=> (fn_irq == 2'b00)); // R4

endmodule

// File: rtl/irq_pd_router.sv
module irq_pd_router
    import irq_pd_pkg::*;
#(
    parameter int unsigned FILTER_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  uart_irq,
    input  logic [1:0]  uart_pd,
    input  logic [1:0]  gp_pin,
    input  logic [1:0]  gp_invert,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        fn0_irq,
    output logic        fn1_irq,
    output logic [1:0]  pd_sticky
);

    ctl_t               ctl;
    logic [1:0]         sticky;
    logic [NUM_PIN-1:0] pin_st;
    logic [1:0]         irq_q;
    logic               pd_hold_f0, pd_now_f1, f0_fire;
    logic [1:0]         clr;

    pin_conditioner #(.N_PINS(NUM_PIN)) u_pins (
        .pin_raw   (gp_pin),
        .invert    (gp_invert),
        .pin_state (pin_st)
    );

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (reg_wr) begin
            ctl.uart_mask <= reg_wdata[B_UMASK  +: NUM_UART];
            ctl.pin_mask  <= reg_wdata[B_PMASK  +: NUM_PIN];
            ctl.pd_mask   <= reg_wdata[B_PDMASK];
            ctl.route     <= reg_wdata[B_ROUTE  +: NUM_PIN];
        end
    end

    // power-down conditions for pin 0
    assign pd_hold_f0 = ctl.pd_mask & ~ctl.route[0] & pin_st[0] & (&uart_pd);
    assign pd_now_f1  = ctl.pd_mask &  ctl.route[0] & pin_st[0];

    pd_filter #(.PERIOD(FILTER_CYCLES)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (pd_hold_f0),
        .fire  (f0_fire)
    );

    // sticky requests: write-1-to-clear, set wins
    assign clr = reg_wr ? reg_wdata[B_STICKY +: 2] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= 2'b00;
        end else begin
            sticky <= (sticky & ~clr) | {pd_now_f1, f0_fire};
        end
    end

    irq_combiner #(.NUM_UART(NUM_UART), .NUM_PIN(NUM_PIN)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .uart_irq  (uart_irq),
        .uart_en   (ctl.uart_mask),
        .pin_state (pin_st),
        .pin_en    (ctl.pin_mask),
        .pin_sel   (ctl.route),
        .fn_irq    (irq_q)
    );

    // read word
    always_comb begin
        reg_rdata = '0;
        reg_rdata[B_UIRQ   +: NUM_UART] = uart_irq;
        reg_rdata[B_PIN    +: NUM_PIN]  = pin_st;
        reg_rdata[B_UMASK  +: NUM_UART] = ctl.uart_mask;
        reg_rdata[B_PMASK  +: NUM_PIN]  = ctl.pin_mask;
        reg_rdata[B_PDMASK]             = ctl.pd_mask;
        reg_rdata[B_STICKY +: 2]        = sticky;
        reg_rdata[B_ROUTE  +: NUM_PIN]  = ctl.route;
    end

    assign fn0_irq   = irq_q[0];
    assign fn1_irq   = irq_q[1];
    assign pd_sticky = sticky;

    AST_F1_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_now_f1 |=> pd_sticky[1]); // R6
    AST_F0_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_sticky[0]) |-> $past(pd_hold_f0)); // R7
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr && pd_sticky[0] |=> pd_sticky[0]); // R9
    AST_PD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.pd_mask && !reg_wr |=> !$rose(pd_sticky[1]) && !$rose(pd_sticky[0])); // R11

endmodule

// File: tb/test_irq_pd_router.sv
module test_irq_pd_router;

    localparam int P = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  uart_irq = '0, uart_pd = '0, gp_pin = '0, gp_invert = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fn0_irq, fn1_irq;
    logic [1:0]  pd_sticky;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_pd_router #(.FILTER_CYCLES(P)) i_irq_pd_router (
        .clk(clk), .rst_n(rst_n), .uart_irq(uart_irq), .uart_pd(uart_pd),
        .gp_pin(gp_pin), .gp_invert(gp_invert), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn0_irq(fn0_irq),
        .fn1_irq(fn1_irq), .pd_sticky(pd_sticky)
    );

    // bench model, written from the requirements
    logic [1:0] m_um, m_pm, m_rt, m_st;
    logic       m_pdm, m_i0, m_i1;
    int         m_run;

    always @(posedge clk or negedge rst_n) begin : mdl
        logic [1:0] p;
        logic c0, c1, f0;
        logic [1:0] cl;
        if (!rst_n) begin
            m_um <= '0; m_pm <= '0; m_rt <= '0; m_st <= '0;
            m_pdm <= 1'b0; m_i0 <= 1'b0; m_i1 <= 1'b0; m_run <= 0;
        end else begin
            p  = gp_pin ^ gp_invert;
            m_i0 <= (|(uart_irq & m_um)) | (p[0] & m_pm[0] & ~m_rt[0]) | (p[1] & m_pm[1] & ~m_rt[1]);
            m_i1 <= (p[0] & m_pm[0] & m_rt[0]) | (p[1] & m_pm[1] & m_rt[1]);
            c0 = m_pdm & ~m_rt[0] & p[0] & uart_pd[0] & uart_pd[1];
            c1 = m_pdm & m_rt[0] & p[0];
            f0 = c0 && (m_run == P - 1);
            m_run <= c0 ? ((m_run < P) ? m_run + 1 : m_run) : 0;
            cl = reg_wr ? reg_wdata[23:22] : 2'b00;
            m_st <= (m_st & ~cl) | {c1, f0};
            if (reg_wr) begin
                m_um <= reg_wdata[17:16]; m_pm <= reg_wdata[19:18];
                m_pdm <= reg_wdata[20];   m_rt <= reg_wdata[27:26];
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        return {4'b0, m_rt, 2'b0, m_st, 1'b0, m_pdm, m_pm, m_um, 12'b0,
                gp_pin ^ gp_invert, uart_irq};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic check_model();
        chk(reg_rdata, exp_rdata(), "R2 R3 R6 R7 R9 read word");
        chk({31'b0, fn0_irq}, {31'b0, m_i0}, "R4 R5 fn0_irq");
        chk({31'b0, fn1_irq}, {31'b0, m_i1}, "R5 fn1_irq");
        chk({30'b0, pd_sticky}, {30'b0, m_st}, "R7 R8 R10 sticky");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        #25 rst_n = 1'b1;
        step();
        // R1
        chk(reg_rdata, 32'h0, "R1 read word after reset");
        chk({30'b0, fn1_irq, fn0_irq}, 32'h0, "R1 irq outputs after reset");
        chk({30'b0, pd_sticky}, 32'h0, "R1 sticky after reset");

        // R2 live status and inversion
        uart_irq = 2'b10; gp_pin = 2'b01; gp_invert = 2'b10; #1;
        chk({28'b0, reg_rdata[3:0]}, 32'hE, "R2 status with inversion");
        gp_invert = 2'b00; #1;
        chk({28'b0, reg_rdata[3:0]}, 32'h6, "R2 status without inversion");
        uart_irq = '0; gp_pin = '0;

        // R3 reserved bits
        wr(32'hFFFF_FFFF);
        chk(reg_rdata, 32'h0C1F_0000, "R3 all-ones write readback");
        wr(32'h0);
        chk(reg_rdata, 32'h0, "R3 all-zero write readback");

        // R4 serial port masks
        wr(32'h0001_0000);
        uart_irq = 2'b01;
        chk({31'b0, fn0_irq}, 32'h0, "R4 fn0 before edge");
        step();
        chk({30'b0, fn1_irq, fn0_irq}, 32'h1, "R4 enabled port 0 to fn0");
        uart_irq = 2'b10;
        step();
        chk({30'b0, fn1_irq, fn0_irq}, 32'h0, "R4 masked port 1 ignored");
        uart_irq = '0;

        // R5 pin routing
        gp_pin = 2'b01;
        wr(32'h0404_0000);
        step();
        chk({30'b0, fn1_irq, fn0_irq}, 32'h2, "R5 pin 0 routed to fn1");
        wr(32'h0004_0000);
        step();
        chk({30'b0, fn1_irq, fn0_irq}, 32'h1, "R5 pin 0 routed to fn0");
        gp_pin = 2'b10;
        wr(32'h0808_0000);
        step();
        chk({30'b0, fn1_irq, fn0_irq}, 32'h2, "R5 pin 1 routed to fn1");
        gp_pin = '0;

        // R6 immediate function 1 request
        wr(32'h0410_0000);
        gp_pin = 2'b01;
        chk({30'b0, pd_sticky}, 32'h0, "R6 sticky before edge");
        step();
        chk({30'b0, pd_sticky}, 32'h2, "R6 fn1 sticky after one edge");
        chk({31'b0, reg_rdata[23]}, 32'h1, "R6 bit 23 readback");
        // R9 set wins over clear
        wr(32'h0490_0000);
        chk({30'b0, pd_sticky}, 32'h2, "R9 set beats clear");
        gp_pin = '0;
        wr(32'h0450_0000);
        chk({30'b0, pd_sticky}, 32'h2, "R9 clearing bit 22 leaves bit 23");
        wr(32'h0410_0000);
        chk({30'b0, pd_sticky}, 32'h2, "R9 writing 0 keeps bit 23");
        wr(32'h0490_0000);
        chk({30'b0, pd_sticky}, 32'h0, "R9 write 1 clears bit 23");

        // R7 filtered function 0 request
        wr(32'h0010_0000);
        uart_pd = 2'b11; gp_pin = 2'b01;
        for (int k = 1; k <= P; k++) begin
            step();
            chk({31'b0, pd_sticky[0]}, {31'b0, (k == P)}, "R7 filter edge count");
        end
        // R10 no refire while held
        wr(32'h0050_0000);
        chk({31'b0, pd_sticky[0]}, 32'h0, "R10 cleared while held");
        for (int k = 0; k < P + 2; k++) step();
        chk({31'b0, pd_sticky[0]}, 32'h0, "R10 stays clear while held");

        // R8 break restarts
        gp_pin = '0; step();
        gp_pin = 2'b01;
        for (int k = 0; k < P - 1; k++) step();
        chk({31'b0, pd_sticky[0]}, 32'h0, "R8 short run");
        uart_pd = 2'b01; step();
        uart_pd = 2'b11;
        for (int k = 0; k < P - 1; k++) step();
        chk({31'b0, pd_sticky[0]}, 32'h0, "R8 count restarted after break");
        step();
        chk({31'b0, pd_sticky[0]}, 32'h1, "R8 full run after restart");

        // R11 power-down enable clear
        wr(32'h00C0_0000);
        for (int k = 0; k < P + 2; k++) step();
        chk({30'b0, pd_sticky}, 32'h0, "R11 no request with enable clear");
        wr(32'h0400_0000);
        step();
        chk({30'b0, pd_sticky}, 32'h0, "R11 fn1 route with enable clear");

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            check_model();
            uart_irq  = 2'($urandom);
            uart_pd   = ($urandom % 8 != 0) ? 2'b11 : 2'($urandom);
            gp_pin    = ($urandom % 10 != 0) ? {1'($urandom), 1'b1} : 2'($urandom);
            gp_invert = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
            if ($urandom % 12 == 0) begin
                reg_wr    = 1'b1;
                reg_wdata = $urandom;
                if ($urandom % 2 == 0) begin
                    reg_wdata[26] = 1'b0;
                    reg_wdata[20] = 1'b1;
                end
            end else begin
                reg_wr = 1'b0;
            end
            step();
        end
        reg_wr = 1'b0;
        check_model();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule